// File: doc/BRIEF.md
# Exclusive Access Monitor for Shared-Cache Lines

This block sits beside a shared cache and resolves load-exclusive / store-exclusive pairs for lines that the cores never hold in their private caches. Because such lines are served only at the shared level, the reservation for every core is kept here. Each core has one reservation: a valid bit and the line tag taken by its most recent load-exclusive. The block watches every access the shared cache serves through a set of observation ports, one access per port per cycle. It judges each store-exclusive, answers pass or fail one cycle later on the same port index, and drops reservations when their line is written. Exclusives to normal cacheable memory are handled inside the private caches and never reach this block.

The scheme is load-linked / store-conditional. Nothing is ever locked. A core that spins on a failing store-exclusive cannot stall another core's accesses. Only a store-exclusive that passes may update memory. The shared cache uses the pass bit to decide whether to commit the write.

Top module: `excl_monitor`

## Requirements
- R1: After a synchronous reset, no core holds a reservation and both `sx_done` and `sx_pass` are 0 on every port.
- R2: A store-exclusive passes when the issuing core's last load-exclusive named the same line and the line has not been written since. The line is the address with its low `LINE_OFF` bits dropped, so the byte offset within the line is ignored. The result shows on `sx_done`/`sx_pass` of the same port one cycle after the access.
- R3: A store-exclusive fails when its core holds no reservation, or holds one for a different line.
- R4: A store-exclusive removes its own core's reservation whether it passes or fails, so a second one without a new load-exclusive fails.
- R5: Each core holds at most one reservation. A new load-exclusive replaces the earlier one, and a store-exclusive to the earlier line then fails.
- R6: A plain store (op `2'b01`) from any core to a line clears every core's reservation on that line. A store to another line leaves reservations intact.
- R7: A store-exclusive that passes counts as a write. It clears the other cores' reservations on that line.
- R8: A plain store and a store-exclusive to the same line in the same cycle, on any two ports: the store-exclusive fails.
- R9: Two store-exclusives to the same line in the same cycle, each with a valid reservation: the lower-numbered port passes and the other fails. If they target different lines, both may pass.
- R10: A plain load (op `2'b00`) has no effect on any reservation.
- R11: A load-exclusive in the same cycle as a write to its line on another port does not establish a reservation.
- R12: `sx_done` on a port is 1 exactly in the cycle after a valid store-exclusive (op `2'b11`) on that port, and 0 otherwise. `sx_pass` is never 1 without `sx_done`. A load-exclusive has op `2'b10`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | NPORT | One bit per observation port: an access is present this cycle |
| acc_core | input | NPORT*CID_W | Issuing core id per port |
| acc_addr | input | NPORT*ADDR_W | Byte address per port |
| acc_op | input | NPORT*2 | Operation per port: 00 load, 01 store, 10 load-exclusive, 11 store-exclusive |
| sx_done | output | NPORT | Registered: a store-exclusive result is presented on this port |
| sx_pass | output | NPORT | Registered: that store-exclusive passed and may commit |

## Verification
The directed bench targets same-cycle races between the two ports. A plain store that collides with a store-exclusive on the same line must make it fail; a design that misses this commits a stale conditional write. Two store-exclusives on one line must yield a single winner; a design that gets this wrong reports success to both cores and breaks mutual exclusion. The bench also checks that a failed store-exclusive consumes the reservation, that a second load-exclusive displaces the first, and that a plain load leaves reservations intact. A monitor that kept reservations alive would let a retry pass on stale data. One that cleared them on reads would cause livelock. A load-exclusive racing a store to its own line must not leave a reservation behind, or a later store-exclusive would pass on data that has already been overwritten.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_LDEX  = 2'b10,
    OP_STEX  = 2'b11
  } acc_op_e;
endpackage

// File: rtl/excl_res_slot.sv
module excl_res_slot
  import excl_mon_pkg::*;
#(
  parameter int TAG_W   = 26,
  parameter int NPORT   = 2,
  parameter int CID_W   = 2,
  parameter int CORE_ID = 0
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NPORT-1:0]             p_v,
  input  logic [NPORT-1:0][CID_W-1:0]  p_core,
  input  logic [NPORT-1:0][1:0]        p_op,
  input  logic [NPORT-1:0][TAG_W-1:0]  p_tag,
  input  logic [NPORT-1:0]             wr_hit,
  output logic                         res_vld,
  output logic [TAG_W-1:0]             res_tag
);
  logic             own_ld, own_sx, kill_old, kill_new;
  logic [TAG_W-1:0] ld_tag;

  always_comb begin
    own_ld   = 1'b0;
    own_sx   = 1'b0;
    ld_tag   = res_tag;
    for (int i = 0; i < NPORT; i++) begin
      if (p_v[i] && p_core[i] == CID_W'(CORE_ID)) begin
        if (p_op[i] == OP_LDEX) begin
          own_ld = 1'b1;
          ld_tag = p_tag[i];
        end
        if (p_op[i] == OP_STEX) own_sx = 1'b1;
      end
    end
    kill_old = 1'b0;
    kill_new = 1'b0;
    for (int i = 0; i < NPORT; i++) begin
      if (wr_hit[i] && res_vld && p_tag[i] == res_tag) kill_old = 1'b1;
      if (wr_hit[i] && p_tag[i] == ld_tag) kill_new = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_vld <= 1'b0;
      res_tag <= '0;
    end else if (own_ld) begin
      res_vld <= !kill_new;
      res_tag <= ld_tag;
    end else if (own_sx || kill_old) begin
      res_vld <= 1'b0;
    end
  end
endmodule

// File: rtl/excl_sx_judge.sv
module excl_sx_judge
  import excl_mon_pkg::*;
#(
  parameter int TAG_W     = 26,
  parameter int NPORT     = 2,
  parameter int CID_W     = 2,
  parameter int NUM_CORES = 4
) (
  input  logic [NPORT-1:0]                p_v,
  input  logic [NPORT-1:0][CID_W-1:0]     p_core,
  input  logic [NPORT-1:0][1:0]           p_op,
  input  logic [NPORT-1:0][TAG_W-1:0]     p_tag,
  input  logic [NUM_CORES-1:0]            res_vld,
  input  logic [NUM_CORES-1:0][TAG_W-1:0] res_tag,
  output logic [NPORT-1:0]                sx_win,
  output logic [NPORT-1:0]                wr_hit
);
  always_comb begin
    logic [NPORT-1:0] win;
    logic             blocked, owned;
    win = '0;
    for (int i = 0; i < NPORT; i++) begin
      owned   = res_vld[p_core[i]] && (res_tag[p_core[i]] == p_tag[i]);
      blocked = 1'b0;
      for (int j = 0; j < NPORT; j++) begin
        if (j != i && p_v[j] && p_op[j] == OP_STORE && p_tag[j] == p_tag[i])
          blocked = 1'b1;
        if (j < i && win[j] && p_tag[j] == p_tag[i])
          blocked = 1'b1;
      end
      win[i] = p_v[i] && (p_op[i] == OP_STEX) && owned && !blocked;
    end
    sx_win = win;
    for (int i = 0; i < NPORT; i++)
      wr_hit[i] = p_v[i] && ((p_op[i] == OP_STORE) || win[i]);
  end
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
  import excl_mon_pkg::*;
#(
  parameter int  NUM_CORES = 4,
  parameter int  NPORT     = 2,
  parameter int  ADDR_W    = 32,
  parameter int  LINE_OFF  = 6,
  localparam int CID_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int TAG_W     = ADDR_W - LINE_OFF
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NPORT-1:0]          acc_valid,
  input  logic [NPORT*CID_W-1:0]    acc_core,
  input  logic [NPORT*ADDR_W-1:0]   acc_addr,
  input  logic [NPORT*2-1:0]        acc_op,
  output logic [NPORT-1:0]          sx_done,
  output logic [NPORT-1:0]          sx_pass
);
  logic [NPORT-1:0][CID_W-1:0]     p_core;
  logic [NPORT-1:0][1:0]           p_op;
  logic [NPORT-1:0][TAG_W-1:0]     p_tag;
  logic [NPORT-1:0]                is_sx, sx_win, wr_hit;
  logic [NUM_CORES-1:0]            res_vld;
  logic [NUM_CORES-1:0][TAG_W-1:0] res_tag;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign p_core[p] = acc_core[p*CID_W +: CID_W];
    assign p_op[p]   = acc_op[p*2 +: 2];
    assign p_tag[p]  = acc_addr[p*ADDR_W + LINE_OFF +: TAG_W];
    assign is_sx[p]  = acc_valid[p] && (p_op[p] == OP_STEX);
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_slot
    excl_res_slot #(
      .TAG_W(TAG_W), .NPORT(NPORT), .CID_W(CID_W), .CORE_ID(c)
    ) u_slot (
      .clk(clk), .rst(rst),
      .p_v(acc_valid), .p_core(p_core), .p_op(p_op), .p_tag(p_tag),
      .wr_hit(wr_hit),
      .res_vld(res_vld[c]), .res_tag(res_tag[c])
    );
  end

  excl_sx_judge #(
    .TAG_W(TAG_W), .NPORT(NPORT), .CID_W(CID_W), .NUM_CORES(NUM_CORES)
  ) u_judge (
    .p_v(acc_valid), .p_core(p_core), .p_op(p_op), .p_tag(p_tag),
    .res_vld(res_vld), .res_tag(res_tag),
    .sx_win(sx_win), .wr_hit(wr_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sx_done <= '0;
      sx_pass <= '0;
    end else begin
      sx_done <= is_sx;
      sx_pass <= sx_win;
    end
  end
endmodule

// File: rtl/excl_mon_chk.sv
module excl_mon_chk #(
  parameter int NUM_CORES = 4,
  parameter int NPORT     = 2,
  parameter int ADDR_W    = 32,
  parameter int LINE_OFF  = 6,
  parameter int CID_W     = 2
) (
  input logic                    clk,
  input logic                    rst,
  input logic [NPORT-1:0]        acc_valid,
  input logic [NPORT*CID_W-1:0]  acc_core,
  input logic [NPORT*ADDR_W-1:0] acc_addr,
  input logic [NPORT*2-1:0]      acc_op,
  input logic [NPORT-1:0]        sx_done,
  input logic [NPORT-1:0]        sx_pass
);
  localparam int TW = ADDR_W - LINE_OFF;
  logic [NUM_CORES-1:0] ever_ld;
  logic [NPORT-1:0] c_sx, c_st, c_ld;
  logic [NPORT-1:0][TW-1:0] c_tag;
  logic [NPORT-1:0][CID_W-1:0] c_core;

  for (genvar i = 0; i < NPORT; i++) begin : g_dec
    assign c_sx[i]   = acc_valid[i] && acc_op[2*i +: 2] == 2'b11;
    assign c_st[i]   = acc_valid[i] && acc_op[2*i +: 2] == 2'b01;
    assign c_ld[i]   = acc_valid[i] && acc_op[2*i +: 2] == 2'b10;
    assign c_tag[i]  = acc_addr[i*ADDR_W + LINE_OFF +: TW];
    assign c_core[i] = acc_core[i*CID_W +: CID_W];
  end

  always_ff @(posedge clk) begin
    if (rst) ever_ld <= '0;
    else
      for (int i = 0; i < NPORT; i++)
        if (c_ld[i]) ever_ld[c_core[i]] <= 1'b1;
  end

  for (genvar i = 0; i < NPORT; i++) begin : g_a
    // R12
    pass_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
      sx_pass[i] |-> sx_done[i]);
    // R12
    done_follows_sx_chk: assert property (@(posedge clk) disable iff (rst)
      c_sx[i] |=> sx_done[i]);
    // R3
    no_resv_fail_chk: assert property (@(posedge clk) disable iff (rst)
      (c_sx[i] && !ever_ld[c_core[i]]) |=> !sx_pass[i]);
    // R4
    resv_consumed_chk: assert property (@(posedge clk) disable iff (rst)
      (c_sx[i] && $past(c_sx[i]) && $past(c_core[i]) == c_core[i]) |=> !sx_pass[i]);
    for (genvar j = 0; j < NPORT; j++) begin : g_b
      if (j != i) begin : g_ne
        // R8
        store_beats_sx_chk: assert property (@(posedge clk) disable iff (rst)
          (c_sx[i] && c_st[j] && c_tag[i] == c_tag[j]) |=> !sx_pass[i]);
      end
      if (j > i) begin : g_gt
        // R9
        single_winner_chk: assert property (@(posedge clk) disable iff (rst)
          (c_sx[i] && c_sx[j] && c_tag[i] == c_tag[j]) |=> !(sx_pass[i] && sx_pass[j]));
      end
    end
  end
endmodule

bind excl_monitor excl_mon_chk #(
  .NUM_CORES(NUM_CORES), .NPORT(NPORT), .ADDR_W(ADDR_W),
  .LINE_OFF(LINE_OFF), .CID_W(CID_W)
) u_chk (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_core(acc_core),
  .acc_addr(acc_addr), .acc_op(acc_op), .sx_done(sx_done), .sx_pass(sx_pass)
);

// File: tb/tb_excl_monitor.sv
`timescale 1ns/1ps
module tb_excl_monitor;
  localparam int NC = 4, NP = 2, AW = 32, LO = 6, CW = 2;
  localparam logic [1:0] LD = 2'b00, ST = 2'b01, LX = 2'b10, SX = 2'b11;

  logic clk = 1'b0, rst = 1'b1;
  logic [NP-1:0] acc_valid = '0;
  logic [NP*CW-1:0] acc_core = '0;
  logic [NP*AW-1:0] acc_addr = '0;
  logic [NP*2-1:0] acc_op = '0;
  logic [NP-1:0] sx_done, sx_pass;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  excl_monitor #(.NUM_CORES(NC), .NPORT(NP), .ADDR_W(AW), .LINE_OFF(LO)) dut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_core(acc_core),
    .acc_addr(acc_addr), .acc_op(acc_op), .sx_done(sx_done), .sx_pass(sx_pass));

  task automatic idle();
    acc_valid = '0; acc_op = '0;
  endtask

  task automatic put(input int p, input int c, input logic [31:0] a, input logic [1:0] o);
    acc_valid[p] = 1'b1;
    acc_core[p*CW +: CW] = CW'(c);
    acc_addr[p*AW +: AW] = a;
    acc_op[p*2 +: 2] = o;
  endtask

  task automatic tick();
    @(negedge clk);
    idle();
  endtask

  task automatic one(input int c, input logic [31:0] a, input logic [1:0] o);
    put(0, c, a, o); tick();
  endtask

  task automatic chk(input int p, input bit ed, input bit ep, input string r);
    checks++;
    if (sx_done[p] !== ed || sx_pass[p] !== ep) begin
      failures++;
      $display("FAIL %s port%0d done/pass actual=%b%b expected=%b%b",
               r, p, sx_done[p], sx_pass[p], ed, ep);
    end
  endtask

  task automatic t_reset();
    chk(0, 0, 0, "R1"); chk(1, 0, 0, "R1");
  endtask

  task automatic t_basic();
    one(0, 32'h1000, LX); chk(0, 0, 0, "R12");
    one(0, 32'h1008, SX); chk(0, 1, 1, "R2");
    tick(); chk(0, 0, 0, "R12");
  endtask

  task automatic t_noresv();
    one(1, 32'h2000, SX); chk(0, 1, 0, "R3");
    one(1, 32'h2000, LX);
    one(1, 32'h2040, SX); chk(0, 1, 0, "R3");
  endtask

  task automatic t_consume();
    one(2, 32'h3000, LX);
    one(2, 32'h3000, SX); chk(0, 1, 1, "R4");
    one(2, 32'h3000, SX); chk(0, 1, 0, "R4");
    one(2, 32'h3040, LX);
    one(2, 32'h3080, SX); chk(0, 1, 0, "R4");
    one(2, 32'h3040, SX); chk(0, 1, 0, "R4");
  endtask

  task automatic t_replace();
    one(3, 32'h4000, LX);
    one(3, 32'h4040, LX);
    one(3, 32'h4000, SX); chk(0, 1, 0, "R5");
    one(3, 32'h4000, LX);
    one(3, 32'h4040, LX);
    one(3, 32'h4040, SX); chk(0, 1, 1, "R5");
  endtask

  task automatic t_store();
    one(0, 32'h5000, LX);
    one(1, 32'h5000, LX);
    one(2, 32'h5010, ST);
    one(0, 32'h5000, SX); chk(0, 1, 0, "R6");
    one(1, 32'h5000, SX); chk(0, 1, 0, "R6");
    one(0, 32'h5000, LX);
    one(2, 32'h5040, ST);
    one(0, 32'h5000, SX); chk(0, 1, 1, "R6");
    one(0, 32'h5080, LX);
    one(1, 32'h5080, LD); chk(0, 0, 0, "R10");
    one(0, 32'h5080, SX); chk(0, 1, 1, "R10");
  endtask

  task automatic t_sx_clear();
    one(0, 32'h6000, LX);
    one(1, 32'h6000, LX);
    one(0, 32'h6000, SX); chk(0, 1, 1, "R7");
    one(1, 32'h6000, SX); chk(0, 1, 0, "R7");
  endtask

  task automatic t_collide();
    one(0, 32'h7000, LX);
    put(0, 1, 32'h7000, ST); put(1, 0, 32'h7000, SX); tick();
    chk(1, 1, 0, "R8"); chk(0, 0, 0, "R8");
    one(0, 32'h7040, LX);
    put(0, 0, 32'h7040, SX); put(1, 1, 32'h7040, ST); tick();
    chk(0, 1, 0, "R8");
  endtask

  task automatic t_race();
    one(0, 32'h8000, LX);
    one(1, 32'h8000, LX);
    put(0, 1, 32'h8000, SX); put(1, 0, 32'h8000, SX); tick();
    chk(0, 1, 1, "R9"); chk(1, 1, 0, "R9");
    one(0, 32'h8040, LX);
    one(1, 32'h8080, LX);
    put(0, 0, 32'h8040, SX); put(1, 1, 32'h8080, SX); tick();
    chk(0, 1, 1, "R9"); chk(1, 1, 1, "R9");
  endtask

  task automatic t_ld_vs_store();
    put(0, 1, 32'h9000, ST); put(1, 0, 32'h9000, LX); tick();
    one(0, 32'h9000, SX); chk(0, 1, 0, "R11");
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_noresv();
    t_consume();
    t_replace();
    t_store();
    t_sx_clear();
    t_collide();
    t_race();
    t_ld_vs_store();
    tick();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule